// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block sits at the output of a clock generator. It switches a group of PCI-domain clock outputs off and back on cleanly while the reference clock keeps running. Two sources can ask for the stop: an active-low asynchronous pin and a run bit held in a control register. The outputs stop when either source is low. Stopped outputs park at logic low. Pulses end and restart only at whole clock phases.

There are two kinds of output. The plain PCI outputs always follow the stop decision. Each flexible output has its own free-run mask bit, which keeps it toggling while the others are halted. A status bit gives the readback for the register bit. It reads 0 whenever the stoppable outputs are halted, so it shows the combined state and not the raw stored value.

The pin passes through a two-flop synchronizer clocked by the rising edge. The decision is then captured on the falling edge of the reference clock, and each output is the reference clock ANDed with its captured enable.

Top module: `clkStopTop`

## Requirements
- R1: While `rstN` is low, every PCI and flexible output is low and `statusRunBit` reads 0, whatever the mask.
- R2: When `stopPinN` is low at rising edge k, the stoppable outputs still give a full pulse at edge k+1 and give no pulse from edge k+2 on.
- R3: When `regRunBit` is cleared between rising edges k and k+1 (while the clock is high), the pulse at edge k+1 is suppressed.
- R4: While stopped, the stoppable outputs stay low through both clock phases.
- R5: When `stopPinN` is high at rising edge k, the register bit is 1, and the outputs were stopped, the first output pulse starts at edge k+2. This is within two clock periods of capture.
- R6: When `regRunBit` is set between edges k and k+1 while the synchronized pin is high, the outputs pulse again at edge k+1.
- R7: A flexible output whose `freeRunMask` bit is 1 toggles with the reference clock whatever the stop request. With the bit at 0 it behaves exactly like a PCI output.
- R8: Every output high pulse starts on a rising reference edge and lasts exactly one high phase, including across stop, restart and mask changes. A mask change made while the clock is high takes effect at the next falling edge.
- R9: `statusRunBit` (1 = running) at the high phase of edge m equals the pin value captured at edge m-2 ANDed with the register bit, for all four pin/register combinations.
- R10: All stoppable outputs stop and start on the same edge. A pin low for a single cycle removes exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopPinN | input | 1 | Asynchronous active-low stop request pin |
| regRunBit | input | 1 | Control register run bit, synchronous to refClk, 0 requests stop |
| freeRunMask | input | NUM_FLEX | Per flexible output free-run enable |
| pciClk | output | NUM_PCI | Stoppable PCI clock outputs |
| flexClk | output | NUM_FLEX | Flexible clock outputs |
| statusRunBit | output | 1 | Readback: 0 while stoppable outputs are halted |

## Verification
The hardest situations are the ones where a gating change lands while the clock is high: a mask flip during a stop, a register bit cleared mid-phase, and a one-cycle pin dip. Only these can expose a shortened pulse or a pulse that is dropped late. The stimulus changes every input half a nanosecond after a rising edge, so each change falls inside the high phase. It then steps through stop/restart from both sources, all four pin/register pairs and every mask value while stopped. An edge-timing monitor on every output measures each pulse against the reference clock.

// File: rtl/clkStopPkg.sv
`timescale 1ns/1ps
package clkStopPkg;
  // Strobes from the control section to the gating datapath
  typedef struct packed {
    logic pinRun;   // synchronized pin, 1 = run
    logic regRun;   // register bit, 1 = run
    logic runReq;   // combined run request
  } gateStrobe_t;
endpackage

// File: rtl/clkStopCtl.sv
`timescale 1ns/1ps
module clkStopCtl
  import clkStopPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        refClk,
  input  logic        rstN,
  input  logic        stopPinN,
  input  logic        regRunBit,
  output gateStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;

  // Asynchronous pin enters the refClk domain through a flop chain
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[LAST-1:0], stopPinN};
  end

  always_comb begin
    strobe.pinRun = syncQ[LAST];
    strobe.regRun = regRunBit;
    strobe.runReq = syncQ[LAST] & regRunBit;
  end
endmodule

// File: rtl/clkStopGate.sv
`timescale 1ns/1ps
module clkStopGate
  import clkStopPkg::*;
#(
  parameter int NUM_PCI  = 4,
  parameter int NUM_FLEX = 2
) (
  input  logic                refClk,
  input  logic                rstN,
  input  gateStrobe_t         strobe,
  input  logic [NUM_FLEX-1:0] freeRunMask,
  output logic [NUM_PCI-1:0]  pciClk,
  output logic [NUM_FLEX-1:0] flexClk,
  output logic                statusRunBit
);
  logic gateEn;

  // Enables change only on the falling edge, while every output is low
  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) gateEn <= 1'b0;
    else       gateEn <= strobe.runReq;
  end

  for (genvar p = 0; p < NUM_PCI; p++) begin : g_pci
    assign pciClk[p] = refClk & gateEn;
  end

  for (genvar f = 0; f < NUM_FLEX; f++) begin : g_flex
    logic flexEn;
    always_ff @(negedge refClk or negedge rstN) begin
      if (!rstN) flexEn <= 1'b0;
      else       flexEn <= strobe.runReq | freeRunMask[f];
    end
    assign flexClk[f] = refClk & flexEn;
  end

  assign statusRunBit = gateEn;
endmodule

// File: rtl/clkStopTop.sv
`timescale 1ns/1ps
module clkStopTop
  import clkStopPkg::*;
#(
  parameter int NUM_PCI     = 4,
  parameter int NUM_FLEX    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic                stopPinN,
  input  logic                regRunBit,
  input  logic [NUM_FLEX-1:0] freeRunMask,
  output logic [NUM_PCI-1:0]  pciClk,
  output logic [NUM_FLEX-1:0] flexClk,
  output logic                statusRunBit
);
  gateStrobe_t strobe;

  clkStopCtl #(.SYNC_STAGES(SYNC_STAGES)) ctl_i (
    .refClk    (refClk),
    .rstN      (rstN),
    .stopPinN  (stopPinN),
    .regRunBit (regRunBit),
    .strobe    (strobe)
  );

  clkStopGate #(.NUM_PCI(NUM_PCI), .NUM_FLEX(NUM_FLEX)) gate_i (
    .refClk       (refClk),
    .rstN         (rstN),
    .strobe       (strobe),
    .freeRunMask  (freeRunMask),
    .pciClk       (pciClk),
    .flexClk      (flexClk),
    .statusRunBit (statusRunBit)
  );
endmodule

// File: rtl/clkStopChk.sv
`timescale 1ns/1ps
module clkStopChk #(
  parameter int NUM_PCI  = 4,
  parameter int NUM_FLEX = 2
) (
  input logic                refClk,
  input logic                rstN,
  input logic                stopPinN,
  input logic                regRunBit,
  input logic [NUM_FLEX-1:0] freeRunMask,
  input logic [NUM_PCI-1:0]  pciClk,
  input logic [NUM_FLEX-1:0] flexClk,
  input logic                statusRunBit
);
  logic [2:0] warm;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)            warm <= '0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
  end

  // R4
  reg_stop_low_chk: assert property (@(negedge refClk) disable iff (!rstN)
    (warm >= 3'd2 && !$past(regRunBit)) |-> (pciClk == '0));

  // R7
  free_run_toggle_chk: assert property (@(negedge refClk) disable iff (!rstN)
    (warm >= 3'd2) |-> ((flexClk & $past(freeRunMask)) == $past(freeRunMask)));

  // R10
  same_edge_chk: assert property (@(negedge refClk) disable iff (!rstN)
    (warm >= 3'd1) |-> ($countones(pciClk) == 0 || $countones(pciClk) == NUM_PCI));

  // R9
  status_combo_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (warm >= 3'd3) |-> (statusRunBit == ($past(stopPinN, 2) && regRunBit)));

  // R1
  reset_quiet_chk: assert property (@(negedge refClk)
    (!rstN) |-> (pciClk == '0 && flexClk == '0 && !statusRunBit));
endmodule

bind clkStopTop clkStopChk #(.NUM_PCI(NUM_PCI), .NUM_FLEX(NUM_FLEX)) chk_i (
  .refClk       (refClk),
  .rstN         (rstN),
  .stopPinN     (stopPinN),
  .regRunBit    (regRunBit),
  .freeRunMask  (freeRunMask),
  .pciClk       (pciClk),
  .flexClk      (flexClk),
  .statusRunBit (statusRunBit)
);

// File: tb/clkStopTop_tb_top.sv
`timescale 1ns/1ps
module clkStopTop_tb_top;
  localparam int NP = 4;
  localparam int NF = 2;

  logic refClk = 1'b0;
  always #2 refClk = ~refClk;

  logic          rstN = 1'b0;
  logic          stopPinN = 1'b1;
  logic          regRunBit = 1'b1;
  logic [NF-1:0] freeRunMask = '0;
  logic [NP-1:0] pciClk;
  logic [NF-1:0] flexClk;
  logic          statusRunBit;

  clkStopTop #(.NUM_PCI(NP), .NUM_FLEX(NF)) dut_i (
    .refClk(refClk), .rstN(rstN), .stopPinN(stopPinN), .regRunBit(regRunBit),
    .freeRunMask(freeRunMask), .pciClk(pciClk), .flexClk(flexClk),
    .statusRunBit(statusRunBit)
  );

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  bit done = 0;

  typedef struct {
    int            edgeNo;
    logic [NP-1:0] pci;
    logic [NF-1:0] flex;
    logic          stat;
    string         tag;
  } exp_t;
  exp_t expQ[$];

  logic pinD1 = 1'b0;
  logic pinD2 = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of inputs in the high phase, push the expected outputs for the next edge
  task automatic step(input logic rstI, input logic pin, input logic regB,
                      input logic [NF-1:0] mask, input string tag);
    exp_t item;
    logic gate;
    @(posedge refClk);
    #0.5;
    rstN = rstI; stopPinN = pin; regRunBit = regB; freeRunMask = mask;
    gate = rstI & pinD2 & regB;
    item.edgeNo = edgeCnt + 1;
    item.pci  = {NP{gate}};
    item.flex = rstI ? (mask | {NF{gate}}) : '0;
    item.stat = gate;
    item.tag  = tag;
    expQ.push_back(item);
    if (!rstI) begin pinD1 = 1'b0; pinD2 = 1'b0; end
    else begin pinD2 = pinD1; pinD1 = pin; end
  endtask

  always @(posedge refClk) edgeCnt++;

  // Monitor: compare outputs in the high phase of each edge
  always @(posedge refClk) begin
    #1;
    if (expQ.size() > 0 && expQ[0].edgeNo == edgeCnt) begin
      exp_t e;
      e = expQ.pop_front();
      check(pciClk === e.pci, e.tag, "pciClk", 8'(pciClk), 8'(e.pci));
      check(flexClk === e.flex, e.tag, "flexClk", 8'(flexClk), 8'(e.flex));
      check(statusRunBit === e.stat, e.tag, "statusRunBit", 8'(statusRunBit), 8'(e.stat));
    end
  end

  // R8: every pulse starts on a rising edge and lasts exactly one high phase
  for (genvar g = 0; g < NP + NF; g++) begin : g_pulse
    wire o = (g < NP) ? pciClk[g % NP] : flexClk[(g - NP) % NF];
    realtime tUp = 0.0;
    always @(posedge o) if (rstN) begin
      tUp = $realtime;
      check(refClk === 1'b1, "R8", "rise off edge", 8'(refClk), 8'd1);
    end
    always @(negedge o) if (rstN && tUp > 0.0) begin
      check(refClk === 1'b0 && ($realtime - tUp) == 2.0, "R8", "pulse width",
            8'(int'($realtime - tUp)), 8'd2);
    end
  end

  initial begin
    repeat (4) step(1'b0, 1'b1, 1'b1, 2'b01, "R1");
    repeat (6) step(1'b1, 1'b1, 1'b1, 2'b01, "R5");
    repeat (6) step(1'b1, 1'b0, 1'b1, 2'b01, "R2/R4");
    repeat (6) step(1'b1, 1'b1, 1'b1, 2'b01, "R5");
    repeat (5) step(1'b1, 1'b1, 1'b0, 2'b10, "R3");
    repeat (5) step(1'b1, 1'b1, 1'b1, 2'b10, "R6");
    for (int c = 0; c < 4; c++) begin
      repeat (5) step(1'b1, c[1], c[0], 2'b00, "R9");
    end
    repeat (4) step(1'b1, 1'b0, 1'b1, 2'b11, "R7");
    step(1'b1, 1'b0, 1'b1, 2'b00, "R7");
    step(1'b1, 1'b0, 1'b1, 2'b01, "R8");
    step(1'b1, 1'b0, 1'b1, 2'b10, "R8");
    step(1'b1, 1'b1, 1'b1, 2'b11, "R8");
    repeat (4) step(1'b1, 1'b1, 1'b1, 2'b00, "R10");
    step(1'b1, 1'b0, 1'b1, 2'b00, "R10");
    repeat (6) step(1'b1, 1'b1, 1'b1, 2'b00, "R10");
    repeat (3) @(posedge refClk);
    #1.5;
    if (expQ.size() != 0) check(1'b0, "R10", "queue left", 8'(expQ.size()), 8'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule